// File: doc/BRIEF.md
# Virtual Address Translation Fault Checker

This block sits beside a translation lookaside buffer and settles the outcome of every instruction fetch, load and store. It takes the virtual address, the access width, the access kind, the address space identifier and the processor status word, together with the lookup result the buffer produced for that address: a hit flag and both halves of the matched entry, each with a frame number, a valid bit and a dirty bit. One cycle later it reports a physical address, an uncacheable flag and a fault code. On a fault it also loads the side fields that an exception handler reads: the faulting virtual address, the page-pair number and its low extension bits, the identifier, and the page-pair number for the context register.

Two kernel windows are not translated. The cached window at 0x8000_0000 and the uncached window at 0xA000_0000 both map straight to physical memory with the top three address bits cleared. Only the cached window is checked for privilege and alignment. Every other address goes through the buffer result, with address faults first, then miss, then invalid half page, then a clean page under a store. A mode input picks 1 KB or 4 KB pages, and this changes which address bit selects the half page and how the physical address is formed.

Top module: `xlat_fault_check`

## Requirements
- R1: Kernel privilege holds when any of status bits 28, 2 or 1 is set, or when status bits 4:3 are 00. Otherwise bits 4:3 = 01 is supervisor, 10 is user and 11 is an invalid mode. Only kernel privilege may access the cached direct window.
- R2: An aligned kernel access with vaddr[31:29] = 100 ignores the buffer result. It returns fault code 0 (none) and physical address {3'b000, vaddr[28:0]}.
- R3: An access with vaddr[31:29] = 100 that is misaligned or made outside kernel privilege raises an address error: code 1 for fetch (type 0) and load (type 1), code 2 for store (type 2). Type code 3 behaves as a load.
- R4: An access with vaddr[31:29] = 101 ignores privilege, alignment and the buffer result. It returns code 0 and physical address {3'b000, vaddr[28:0]}.
- R5: An access is misaligned when vaddr[2:0] AND ((1 << size) − 1) is nonzero, where size is the base-2 log of the byte count. A misaligned mapped access raises code 1 or 2 as in R3, ahead of every buffer-derived fault.
- R6: A mapped aligned access that misses raises code 3 (fetch refill) or code 4 (data refill).
- R7: On a mapped aligned hit, the half page is chosen by vaddr[12] with 4 KB pages or vaddr[10] with 1 KB pages (0 = even half). If the chosen half has a clear valid bit, the access raises code 5 (fetch invalid) or code 6 (data invalid).
- R8: A store to a valid half page whose dirty bit is clear raises code 7 (modified). A fetch or load to such a page completes.
- R9: A mapped access that completes returns {frame[21:2], vaddr[11:0]} with 4 KB pages or {frame[21:0], vaddr[9:0]} with 1 KB pages, using the chosen half's frame.
- R10: Codes 3 to 7 load the bad-address register with vaddr, the page-pair fields with vaddr[31:13], the extension field with vaddr[12:11] (1 KB pages) or 00 (4 KB pages), and the identifier field with the request identifier.
- R11: Codes 1 and 2 load only the bad-address register. A response with code 0 and an idle cycle leave every side field unchanged. All side fields reset to zero.
- R12: The uncacheable flag is set exactly when vaddr AND 0xA000_0000 equals 0xA000_0000, whether or not the access faults.
- R13: Results appear on the clock edge after the request with resp_valid high. On a fault or an idle cycle, the physical address is zero. An idle cycle also gives code 0 and a clear uncacheable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_size | input | 2 | Base-2 log of the access byte count |
| req_type | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| req_asid | input | ASID_W | Address space identifier |
| status | input | 32 | Processor status word |
| fine_pages | input | 1 | 1 selects 1 KB pages, 0 selects 4 KB pages |
| tlb_hit | input | 1 | Buffer found a matching entry |
| tlb_v0 | input | 1 | Even half valid |
| tlb_v1 | input | 1 | Odd half valid |
| tlb_d0 | input | 1 | Even half dirty (writable) |
| tlb_d1 | input | 1 | Odd half dirty (writable) |
| tlb_pfn0 | input | 22 | Even half frame number |
| tlb_pfn1 | input | 22 | Odd half frame number |
| resp_valid | output | 1 | Result valid |
| resp_paddr | output | 32 | Physical address |
| resp_uncached | output | 1 | Uncacheable access |
| resp_fault | output | 4 | Fault code, 0 = none |
| bad_vaddr | output | 32 | Faulting virtual address |
| hi_vpn2 | output | 19 | Faulting page-pair number |
| hi_vpn2x | output | 2 | Page-pair extension bits |
| hi_asid | output | ASID_W | Identifier of the faulting access |
| ctx_badvpn2 | output | 19 | Page-pair number for the context register |

## Verification
The bench aims at priority and at the boundaries between windows and modes. Examples are a misaligned access that also misses (a design with the wrong order reports a refill), a store to a clean page against a load to the same page (a design that checks dirtiness on loads faults the load), and the invalid privilege encoding 11 (a design that treats it as kernel lets the direct window through). It also covers addresses in the 0xE000_0000 window, which are mapped but still uncacheable; a design that ties the flag to the uncached window alone misses them. It also checks that address errors leave the page-pair fields untouched, and that 1 KB mode moves both the half-page select bit and the extension field.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W        = 32;
    localparam int FINE_SHIFT  = 10;
    localparam int COARSE_SHIFT = 12;
    localparam int PFN_W       = VA_W - FINE_SHIFT;
    localparam int VPN2_LSB    = COARSE_SHIFT + 1;
    localparam int VPN2_W      = VA_W - VPN2_LSB;
    localparam int SEG_W       = 3;

    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'd0,
        PRIV_SUPER  = 2'd1,
        PRIV_USER   = 2'd2,
        PRIV_BAD    = 2'd3
    } priv_e;

    typedef enum logic [3:0] {
        FLT_NONE     = 4'd0,
        FLT_ADR_LD   = 4'd1,
        FLT_ADR_ST   = 4'd2,
        FLT_REFILL_I = 4'd3,
        FLT_REFILL_D = 4'd4,
        FLT_INVAL_I  = 4'd5,
        FLT_INVAL_D  = 4'd6,
        FLT_MOD      = 4'd7
    } flt_e;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd2;
endpackage

// File: rtl/xlat_priv_decode.sv
module xlat_priv_decode
    import xlat_pkg::*;
(
    input  logic [31:0] status,
    output priv_e       priv
);
    logic override_k;
    logic unused_status;

    assign override_k    = status[28] | status[2] | status[1];
    assign unused_status = ^{status[31:29], status[27:5], status[0]};

    always_comb begin
        if (override_k) begin
            priv = PRIV_KERNEL;
        end else begin
            unique case (status[4:3])
                2'b00:   priv = PRIV_KERNEL;
                2'b01:   priv = PRIV_SUPER;
                2'b10:   priv = PRIV_USER;
                default: priv = PRIV_BAD;
            endcase
        end
    end
endmodule

// File: rtl/xlat_seg_decode.sv
module xlat_seg_decode
    import xlat_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  logic [1:0]      size,
    output logic            win_cached,
    output logic            win_uncached,
    output logic            misaligned,
    output logic            uncached,
    output logic [VA_W-1:0] direct_paddr
);
    localparam logic [SEG_W-1:0] SEG_K0 = 3'b100;
    localparam logic [SEG_W-1:0] SEG_K1 = 3'b101;
    localparam logic [VA_W-1:0]  UC_PAT = 32'hA000_0000;

    logic [2:0] lane_mask;

    assign lane_mask    = 3'((4'd1 << size) - 4'd1);
    assign misaligned   = |(vaddr[2:0] & lane_mask);
    assign win_cached   = (vaddr[VA_W-1 -: SEG_W] == SEG_K0);
    assign win_uncached = (vaddr[VA_W-1 -: SEG_W] == SEG_K1);
    assign uncached     = ((vaddr & UC_PAT) == UC_PAT);
    assign direct_paddr = {{SEG_W{1'b0}}, vaddr[VA_W-SEG_W-1:0]};
endmodule

// File: rtl/xlat_page_sel.sv
module xlat_page_sel
    import xlat_pkg::*;
(
    input  logic [VA_W-1:0]   vaddr,
    input  logic              fine_pages,
    input  logic              v0,
    input  logic              v1,
    input  logic              d0,
    input  logic              d1,
    input  logic [PFN_W-1:0]  pfn0,
    input  logic [PFN_W-1:0]  pfn1,
    output logic              sel_valid,
    output logic              sel_dirty,
    output logic [VA_W-1:0]   mapped_paddr,
    output logic [VPN2_W-1:0] vpn2,
    output logic [1:0]        vpn2x
);
    logic             odd_half;
    logic [PFN_W-1:0] pfn_sel;

    assign odd_half  = fine_pages ? vaddr[FINE_SHIFT] : vaddr[COARSE_SHIFT];
    assign sel_valid = odd_half ? v1 : v0;
    assign sel_dirty = odd_half ? d1 : d0;
    assign pfn_sel   = odd_half ? pfn1 : pfn0;

    always_comb begin
        if (fine_pages) begin
            mapped_paddr = {pfn_sel, vaddr[FINE_SHIFT-1:0]};
        end else begin
            mapped_paddr = {pfn_sel[PFN_W-1:COARSE_SHIFT-FINE_SHIFT],
                            vaddr[COARSE_SHIFT-1:0]};
        end
    end

    assign vpn2  = vaddr[VA_W-1:VPN2_LSB];
    assign vpn2x = fine_pages ? vaddr[COARSE_SHIFT:FINE_SHIFT+1] : 2'b00;
endmodule

// File: rtl/xlat_fault_check.sv
module xlat_fault_check
    import xlat_pkg::*;
#(
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_vaddr,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_type,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [31:0]       status,
    input  logic              fine_pages,
    input  logic              tlb_hit,
    input  logic              tlb_v0,
    input  logic              tlb_v1,
    input  logic              tlb_d0,
    input  logic              tlb_d1,
    input  logic [21:0]       tlb_pfn0,
    input  logic [21:0]       tlb_pfn1,
    output logic              resp_valid,
    output logic [31:0]       resp_paddr,
    output logic              resp_uncached,
    output logic [3:0]        resp_fault,
    output logic [31:0]       bad_vaddr,
    output logic [18:0]       hi_vpn2,
    output logic [1:0]        hi_vpn2x,
    output logic [ASID_W-1:0] hi_asid,
    output logic [18:0]       ctx_badvpn2
);
    typedef struct packed {
        logic              vld;
        logic [VA_W-1:0]   paddr;
        logic              unc;
        flt_e              fault;
        logic [VA_W-1:0]   bad;
        logic [VPN2_W-1:0] vpn2;
        logic [1:0]        vpn2x;
        logic [ASID_W-1:0] asid;
        logic [VPN2_W-1:0] ctx;
    } st_t;

    st_t st_d, st_q;

    priv_e             priv;
    logic              win_c, win_u, mis, unc;
    logic [VA_W-1:0]   direct_pa, mapped_pa;
    logic              sel_valid, sel_dirty;
    logic [VPN2_W-1:0] vpn2;
    logic [1:0]        vpn2x;

    xlat_priv_decode u_priv (
        .status (status),
        .priv   (priv)
    );

    xlat_seg_decode u_seg (
        .vaddr        (req_vaddr),
        .size         (req_size),
        .win_cached   (win_c),
        .win_uncached (win_u),
        .misaligned   (mis),
        .uncached     (unc),
        .direct_paddr (direct_pa)
    );

    xlat_page_sel u_page (
        .vaddr        (req_vaddr),
        .fine_pages   (fine_pages),
        .v0           (tlb_v0),
        .v1           (tlb_v1),
        .d0           (tlb_d0),
        .d1           (tlb_d1),
        .pfn0         (tlb_pfn0),
        .pfn1         (tlb_pfn1),
        .sel_valid    (sel_valid),
        .sel_dirty    (sel_dirty),
        .mapped_paddr (mapped_pa),
        .vpn2         (vpn2),
        .vpn2x        (vpn2x)
    );

    logic is_store, is_fetch;
    flt_e adr_code;
    assign is_store = (req_type == ACC_STORE);
    assign is_fetch = (req_type == ACC_FETCH);
    assign adr_code = is_store ? FLT_ADR_ST : FLT_ADR_LD;

    always_comb begin
        logic tlb_fault;
        st_d       = st_q;
        st_d.vld   = req_valid;
        st_d.paddr = '0;
        st_d.unc   = 1'b0;
        st_d.fault = FLT_NONE;
        tlb_fault  = 1'b0;
        if (req_valid) begin
            st_d.unc = unc;
            if (win_c) begin
                if (mis || priv != PRIV_KERNEL) st_d.fault = adr_code;
                else                             st_d.paddr = direct_pa;
            end else if (win_u) begin
                st_d.paddr = direct_pa;
            end else if (mis) begin
                st_d.fault = adr_code;
            end else if (!tlb_hit) begin
                st_d.fault = is_fetch ? FLT_REFILL_I : FLT_REFILL_D;
                tlb_fault  = 1'b1;
            end else if (!sel_valid) begin
                st_d.fault = is_fetch ? FLT_INVAL_I : FLT_INVAL_D;
                tlb_fault  = 1'b1;
            end else if (is_store && !sel_dirty) begin
                st_d.fault = FLT_MOD;
                tlb_fault  = 1'b1;
            end else begin
                st_d.paddr = mapped_pa;
            end
            if (st_d.fault != FLT_NONE) st_d.bad = req_vaddr;
            if (tlb_fault) begin
                st_d.vpn2  = vpn2;
                st_d.vpn2x = vpn2x;
                st_d.asid  = req_asid;
                st_d.ctx   = vpn2;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid    = st_q.vld;
    assign resp_paddr    = st_q.paddr;
    assign resp_uncached = st_q.unc;
    assign resp_fault    = st_q.fault;
    assign bad_vaddr     = st_q.bad;
    assign hi_vpn2       = st_q.vpn2;
    assign hi_vpn2x      = st_q.vpn2x;
    assign hi_asid       = st_q.asid;
    assign ctx_badvpn2   = st_q.ctx;

    // R4: uncached direct window never faults
    a_r4_kseg_unc_nofault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vaddr[31:29] == 3'b101) |=> (resp_fault == 4'd0));

    // R8: modified fault only for stores
    a_r8_mod_only_store: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type != ACC_STORE) |=> (resp_fault != 4'd7));

    // R11: side fields hold when no fault is reported
    a_r11_side_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_fault == 4'd0) |-> ($stable(bad_vaddr) && $stable(hi_vpn2) &&
                                  $stable(hi_vpn2x) && $stable(ctx_badvpn2)));

    // R13: a fault carries a zero physical address and a valid response
    a_r13_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_fault != 4'd0) |-> (resp_valid && resp_paddr == '0));

    // R5: misalignment in a mapped window beats every buffer fault
    a_r5_mis_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vaddr[31:30] != 2'b10 && (req_vaddr[0] && req_size != 2'd0))
        |=> (resp_fault == 4'd1 || resp_fault == 4'd2));

    // R10: page-pair and context copies agree
    a_r10_ctx_match: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_vpn2 == ctx_badvpn2));
endmodule

// File: tb/tb_xlat_fault_check.sv
`timescale 1ns/1ps
module tb_xlat_fault_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_type = '0;
    logic [7:0]  req_asid = '0;
    logic [31:0] status = '0;
    logic        fine_pages = 1'b0;
    logic        tlb_hit = 1'b0, tlb_v0 = 1'b0, tlb_v1 = 1'b0, tlb_d0 = 1'b0, tlb_d1 = 1'b0;
    logic [21:0] tlb_pfn0 = '0, tlb_pfn1 = '0;
    logic        resp_valid, resp_uncached;
    logic [31:0] resp_paddr, bad_vaddr;
    logic [3:0]  resp_fault;
    logic [18:0] hi_vpn2, ctx_badvpn2;
    logic [1:0]  hi_vpn2x;
    logic [7:0]  hi_asid;

    xlat_fault_check #(.ASID_W(8)) dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // expected state
    logic [31:0] e_pa, e_bad;
    logic [3:0]  e_f;
    logic        e_unc, e_vld;
    logic [18:0] e_vpn2;
    logic [1:0]  e_x;
    logic [7:0]  e_asid;
    string       t_f, t_pa, t_side;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_kernel(input logic [31:0] s);
        return (s[28] | s[2] | s[1]) || (s[4:3] == 2'b00);
    endfunction

    task automatic model();
        bit mis, odd, v, d, tlbf;
        logic [21:0] pfn;
        logic [3:0]  adr;
        mis  = (req_vaddr[2:0] & 3'((4'd1 << req_size) - 4'd1)) != 0;
        adr  = (req_type == 2'd2) ? 4'd2 : 4'd1;
        e_vld = req_valid;
        e_pa = '0; e_f = 4'd0; e_unc = 1'b0; tlbf = 0;
        t_f = "R13"; t_pa = "R13"; t_side = "R11";
        if (!req_valid) return;
        e_unc = (req_vaddr & 32'hA000_0000) == 32'hA000_0000;
        odd = fine_pages ? req_vaddr[10] : req_vaddr[12];
        v   = odd ? tlb_v1 : tlb_v0;
        d   = odd ? tlb_d1 : tlb_d0;
        pfn = odd ? tlb_pfn1 : tlb_pfn0;
        if (req_vaddr[31:29] == 3'b100) begin
            t_f = mis ? "R3" : "R1";
            if (mis || !is_kernel(status)) e_f = adr;
            else begin e_pa = {3'b000, req_vaddr[28:0]}; t_pa = "R2"; end
        end else if (req_vaddr[31:29] == 3'b101) begin
            t_f = "R4"; t_pa = "R4";
            e_pa = {3'b000, req_vaddr[28:0]};
        end else if (mis) begin
            t_f = "R5"; e_f = adr;
        end else if (!tlb_hit) begin
            t_f = "R6"; e_f = (req_type == 2'd0) ? 4'd3 : 4'd4; tlbf = 1;
        end else if (!v) begin
            t_f = "R7"; e_f = (req_type == 2'd0) ? 4'd5 : 4'd6; tlbf = 1;
        end else if (req_type == 2'd2 && !d) begin
            t_f = "R8"; e_f = 4'd7; tlbf = 1;
        end else begin
            t_f = d ? "R9" : "R8"; t_pa = "R9";
            e_pa = fine_pages ? {pfn, req_vaddr[9:0]} : {pfn[21:2], req_vaddr[11:0]};
        end
        if (e_f != 0) e_bad = req_vaddr;
        if (tlbf) begin
            t_side = "R10";
            e_vpn2 = req_vaddr[31:13];
            e_x    = fine_pages ? req_vaddr[12:11] : 2'b00;
            e_asid = req_asid;
        end
    endtask

    task automatic compare();
        chk(resp_valid == e_vld, "R13", "valid", 32'(resp_valid), 32'(e_vld));
        chk(resp_fault == e_f, t_f, "fault", 32'(resp_fault), 32'(e_f));
        chk(resp_paddr == e_pa, t_pa, "paddr", resp_paddr, e_pa);
        chk(resp_uncached == e_unc, "R12", "uncached", 32'(resp_uncached), 32'(e_unc));
        chk(bad_vaddr == e_bad, t_side, "bad_vaddr", bad_vaddr, e_bad);
        chk(hi_vpn2 == e_vpn2 && ctx_badvpn2 == e_vpn2, t_side, "vpn2/ctx",
            32'(hi_vpn2), 32'(e_vpn2));
        chk(hi_vpn2x == e_x, t_side, "vpn2x", 32'(hi_vpn2x), 32'(e_x));
        chk(hi_asid == e_asid, t_side, "asid", 32'(hi_asid), 32'(e_asid));
    endtask

    // inputs driven at negedge, result sampled at the following negedge
    task automatic step();
        model();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic req(input logic [31:0] va, input logic [1:0] sz, input logic [1:0] ty,
                       input logic [31:0] st, input bit fine, input bit hit,
                       input bit v0, input bit v1, input bit d0, input bit d1);
        req_valid = 1'b1; req_vaddr = va; req_size = sz; req_type = ty;
        status = st; fine_pages = fine; tlb_hit = hit;
        tlb_v0 = v0; tlb_v1 = v1; tlb_d0 = d0; tlb_d1 = d1;
        req_asid = 8'($urandom);
        tlb_pfn0 = 22'($urandom); tlb_pfn1 = 22'($urandom);
        step();
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        e_bad = '0; e_vpn2 = '0; e_x = '0; e_asid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state R11 / R13
        model();
        compare();

        // R2 kernel aligned load in cached window
        req(32'h8123_4568, 2'd2, 2'd1, 32'h0000_0000, 0, 0, 0, 0, 0, 0);
        // R3 user store in cached window -> code 2
        req(32'h8000_1000, 2'd2, 2'd2, 32'h0000_0010, 0, 1, 1, 1, 1, 1);
        // R1 invalid mode 11 fetch -> address error
        req(32'h9000_0000, 2'd2, 2'd0, 32'h0000_0018, 0, 1, 1, 1, 1, 1);
        // R1 supervisor load, then bit 28 override gives kernel
        req(32'h8000_0040, 2'd0, 2'd1, 32'h0000_0008, 0, 0, 0, 0, 0, 0);
        req(32'h8000_0040, 2'd0, 2'd1, 32'h1000_0018, 0, 0, 0, 0, 0, 0);
        // R3 kernel misaligned fetch in cached window
        req(32'h8000_0002, 2'd2, 2'd0, 32'h0000_0000, 0, 1, 1, 1, 1, 1);
        // R4 uncached window, user, misaligned, miss -> no fault
        req(32'hA000_0003, 2'd2, 2'd2, 32'h0000_0010, 0, 0, 0, 0, 0, 0);
        // R5 misaligned mapped load with miss -> address error, not refill
        req(32'h0040_0001, 2'd1, 2'd1, 32'h0000_0010, 0, 0, 0, 0, 0, 0);
        // R6 fetch miss, data miss
        req(32'h0040_2000, 2'd2, 2'd0, 32'h0000_0010, 1, 0, 1, 1, 1, 1);
        req(32'hC000_3800, 2'd2, 2'd1, 32'h0000_0010, 1, 0, 1, 1, 1, 1);
        // R7 odd half invalid with fine pages (bit 10 set)
        req(32'h0000_1C00, 2'd2, 2'd1, 32'h0000_0010, 1, 1, 1, 0, 1, 1);
        // R8 store to clean page, load to same page
        req(32'h0000_0000, 2'd2, 2'd2, 32'h0000_0010, 0, 1, 1, 1, 0, 0);
        req(32'h0000_0000, 2'd2, 2'd1, 32'h0000_0010, 0, 1, 1, 1, 0, 0);
        // R9 coarse odd half success
        req(32'h1234_5678, 2'd2, 2'd2, 32'h0000_0010, 0, 1, 0, 1, 0, 1);
        // R12 mapped window at 0xE0000000 stays uncacheable
        req(32'hE000_0100, 2'd2, 2'd1, 32'h0000_0000, 0, 1, 1, 1, 1, 1);
        // R11 idle cycle keeps side fields
        req_valid = 1'b0;
        step();

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] va, st;
            int pick;
            pick = int'($urandom_range(0, 4));
            va = $urandom;
            if (pick == 0) va[31:29] = 3'b100;
            else if (pick == 1) va[31:29] = 3'b101;
            if ($urandom_range(0, 1) == 1) va[2:0] = 3'b000;
            st = $urandom;
            if ($urandom_range(0, 1) == 1) st = st & ~32'h1000_0006;
            req_valid = ($urandom_range(0, 7) != 0);
            req_vaddr = va; req_size = 2'($urandom); req_type = 2'($urandom);
            req_asid = 8'($urandom); status = st; fine_pages = 1'($urandom);
            tlb_hit = 1'($urandom); tlb_v0 = 1'($urandom); tlb_v1 = 1'($urandom);
            tlb_d0 = 1'($urandom); tlb_d1 = 1'($urandom);
            tlb_pfn0 = 22'($urandom); tlb_pfn1 = 22'($urandom);
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule